// File: doc/BRIEF.md
# IDE Strobe Cycle Timing Encoder

This block turns three bus timing requests given in nanoseconds into clock counts for a host bus clock of known period. The three requests are the full transfer cycle, the active strobe width and the address setup time. The cycle and active counts are folded into one drive timing byte: the active count goes in the upper nibble and a coded recovery count in the lower nibble. The setup count comes out on its own together with a 2-bit setup code.

Each request is applied with an input strobe. The results appear one clock later with an output strobe, and they stay unchanged until the next request. Counts that cannot be represented are clamped, and an overflow flag reports the clamp. A period input of zero selects a built-in default period.

Top module: `ide_strobe_timing_enc`

## Requirements
- R1: Each time is converted to clocks by rounding up: count = (time + period - 1) / period, using integer division.
- R2: A period input of 0 selects a period of 30 ns (parameter DEF_PERIOD).
- R3: The recovery count is the cycle count minus the active count. It is 0 when the active count is greater than or equal to the cycle count.
- R4: When the recovery count exceeds 16, the active count grows by the excess and the recovery count becomes 16.
- R5: The recovery count is coded into timing_byte[3:0] as follows: 0 or 1 gives 15, n from 2 to 15 gives n-1, and 16 gives 0.
- R6: timing_byte[7:4] holds the final active count modulo 16, so an active count of 16 reads as 0.
- R7: A final active count above 16 is clamped to 16 and raises overflow.
- R8: setup_cnt is the rounded-up setup count. When it is above 5 it is clamped to 5 and raises overflow.
- R9: setup_code encodes setup_cnt as follows: 0, 1 or 2 gives 2'b01, 3 gives 2'b10, 4 gives 2'b00, and 5 gives 2'b11.
- R10: overflow is 0 whenever no clamp from R7 or R8 applied. In particular, an active count of exactly 16 or a setup count of exactly 5 does not raise it.
- R11: Results and out_valid appear on the clock after in_valid. out_valid equals in_valid of the previous cycle. Without in_valid, all result outputs keep their values whatever the other inputs do.
- R12: While rst_n is low, out_valid, timing_byte, setup_cnt, setup_code and overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| cycle_ns | input | TW (10) | Total cycle time, ns |
| active_ns | input | TW (10) | Active strobe time, ns |
| setup_ns | input | TW (10) | Address setup time, ns |
| period_ns | input | PW (8) | Bus clock period, ns; 0 selects default |
| out_valid | output | 1 | Result strobe |
| timing_byte | output | 8 | Packed active and recovery code |
| setup_cnt | output | 3 | Final setup count |
| setup_code | output | 2 | Coded setup count |
| overflow | output | 1 | A clamp was applied |

## Verification
Requests are chosen so that the recovery count lands on each distinct path:
- a normal difference;
- an active time longer than the cycle, which yields zero recovery;
- an excess that moves into the active count;
- an excess so large that the active count clamps.

Further cases sit exactly at the boundaries (recovery 16, active 16, setup 5). These separate the inclusive limits from the clamping ones. A sweep of setup counts 0 to 7 covers every setup code as well as the clamp. Idle cycles with changing inputs, and back-to-back strobes, show that results are taken only on a strobe and that each result lands one clock later.

// File: rtl/ide_strobe_timing_enc.sv
module ide_strobe_timing_enc #(
  parameter int TW         = 10,
  parameter int PW         = 8,
  parameter int DEF_PERIOD = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] cycle_ns,
  input  logic [TW-1:0] active_ns,
  input  logic [TW-1:0] setup_ns,
  input  logic [PW-1:0] period_ns,
  output logic          out_valid,
  output logic [7:0]    timing_byte,
  output logic [2:0]    setup_cnt,
  output logic [1:0]    setup_code,
  output logic          overflow
);
  localparam int SW = TW + 1;

  function automatic logic [SW-1:0] to_clocks(input logic [TW-1:0] t, input logic [PW-1:0] p);
    logic [SW-1:0] num;
    num = SW'(t) + SW'(p) - SW'(1);
    return num / SW'(p);
  endfunction

  logic [PW-1:0] per;
  logic [SW-1:0] cyc_c, act_c, set_c, rec_raw, act_adj, act_fin, rec_cap;
  logic          rec_big, act_ovf, set_ovf;
  logic [3:0]    rec_code;
  logic [2:0]    set_fin;
  logic [1:0]    set_code;

  assign per     = (period_ns == '0) ? PW'(DEF_PERIOD) : period_ns;
  assign cyc_c   = to_clocks(cycle_ns, per);
  assign act_c   = to_clocks(active_ns, per);
  assign set_c   = to_clocks(setup_ns, per);

  assign rec_raw = (act_c >= cyc_c) ? '0 : cyc_c - act_c;
  assign rec_big = rec_raw > SW'(16);
  assign act_adj = rec_big ? cyc_c - SW'(16) : act_c;
  assign rec_cap = rec_big ? SW'(16) : rec_raw;
  assign act_ovf = act_adj > SW'(16);
  assign act_fin = act_ovf ? SW'(16) : act_adj;
  assign set_ovf = set_c > SW'(5);
  assign set_fin = set_ovf ? 3'd5 : set_c[2:0];

  always_comb begin
    case (rec_cap[4:0])
      5'd0, 5'd1: rec_code = 4'd15;
      5'd16:      rec_code = 4'd0;
      default:    rec_code = rec_cap[3:0] - 4'd1;
    endcase
  end

  always_comb begin
    case (set_fin)
      3'd3:    set_code = 2'b10;
      3'd4:    set_code = 2'b00;
      3'd5:    set_code = 2'b11;
      default: set_code = 2'b01;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      timing_byte <= '0;
      setup_cnt   <= '0;
      setup_code  <= '0;
      overflow    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        timing_byte <= {act_fin[3:0], rec_code};
        setup_cnt   <= set_fin;
        setup_code  <= set_code;
        overflow    <= act_ovf | set_ovf;
      end
    end
  end
endmodule

module ide_strobe_timing_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [7:0] timing_byte,
  input logic [2:0] setup_cnt,
  input logic [1:0] setup_code,
  input logic       overflow
);
  // R11
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(timing_byte) && $stable(setup_cnt) && $stable(overflow)));

  // R8
  setup_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> setup_cnt <= 3'd5);

  // R9
  setup_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> setup_code == ((setup_cnt == 3'd3) ? 2'b10 :
                                 (setup_cnt == 3'd4) ? 2'b00 :
                                 (setup_cnt == 3'd5) ? 2'b11 : 2'b01));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && setup_cnt != 3'd5 && timing_byte[7:4] != 4'd0) |-> !overflow);
endmodule

bind ide_strobe_timing_enc ide_strobe_timing_enc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .timing_byte(timing_byte), .setup_cnt(setup_cnt), .setup_code(setup_code),
  .overflow(overflow)
);

// File: tb/test_ide_strobe_timing_enc.sv
`timescale 1ns/1ps
module test_ide_strobe_timing_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] cycle_ns = '0, active_ns = '0, setup_ns = '0;
  logic [7:0] period_ns = '0;
  logic       out_valid, overflow;
  logic [7:0] timing_byte;
  logic [2:0] setup_cnt;
  logic [1:0] setup_code;

  int checks = 0, errors = 0;
  string cur_tag = "R12";

  bit     e_v = 0, e_ov = 0;
  int     e_byte = 0, e_scnt = 0, e_scode = 0;
  string  e_tag = "R12";

  always #2.5 clk = ~clk;

  ide_strobe_timing_enc i_ide_strobe_timing_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cycle_ns(cycle_ns),
    .active_ns(active_ns), .setup_ns(setup_ns), .period_ns(period_ns),
    .out_valid(out_valid), .timing_byte(timing_byte), .setup_cnt(setup_cnt),
    .setup_code(setup_code), .overflow(overflow)
  );

  function automatic int ceil_clk(int t, int p);
    return (t + p - 1) / p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v = 0; e_ov = 0; e_byte = 0; e_scnt = 0; e_scode = 0; e_tag = "R12";
    end else begin
      e_v = in_valid;
      if (in_valid) begin
        int p, c, a, s, r, rc;
        p = (period_ns == 0) ? 30 : int'(period_ns);
        c = ceil_clk(int'(cycle_ns), p);
        a = ceil_clk(int'(active_ns), p);
        s = ceil_clk(int'(setup_ns), p);
        r = (a >= c) ? 0 : c - a;
        if (r > 16) begin a = a + (r - 16); r = 16; end
        e_ov = 0;
        if (a > 16) begin a = 16; e_ov = 1; end
        if (s > 5) begin s = 5; e_ov = 1; end
        if (r <= 1) rc = 15;
        else if (r == 16) rc = 0;
        else rc = r - 1;
        e_byte  = (a % 16) * 16 + rc;
        e_scnt  = s;
        e_scode = (s <= 2) ? 1 : (s == 3) ? 2 : (s == 4) ? 0 : 3;
        e_tag   = cur_tag;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(rst_n ? "R11" : "R12", "out_valid", int'(out_valid), int'(e_v));
    chk(e_tag, "timing_byte", int'(timing_byte), e_byte);
    chk(e_tag, "setup_cnt", int'(setup_cnt), e_scnt);
    chk(e_tag, "setup_code", int'(setup_code), e_scode);
    chk(e_tag, "overflow", int'(overflow), int'(e_ov));
  end

  task automatic req(string tag, int cyc, int act, int st, int per);
    cur_tag   = tag;
    cycle_ns  = 10'(cyc);
    active_ns = 10'(act);
    setup_ns  = 10'(st);
    period_ns = 8'(per);
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req("R1_R2", 600, 290, 70, 0);
    req("R5", 120, 70, 30, 30);
    req("R1", 480, 215, 25, 30);
    req("R3", 100, 200, 10, 25);
    req("R4", 900, 90, 30, 30);
    req("R7", 1000, 30, 10, 20);
    req("R7", 300, 300, 0, 15);
    req("R8", 300, 100, 200, 30);
    for (int k = 0; k < 8; k++) req("R9", 300, 100, k * 30, 30);
    req("R10", 256, 256, 75, 16);
    req("R4", 320, 0, 0, 16);
    req("R6", 255, 80, 5, 5);
    req("R3", 60, 60, 1, 30);
    @(negedge clk);
    cur_tag = "R11";
    cycle_ns = 10'd999; active_ns = 10'd1; setup_ns = 10'd999; period_ns = 8'd1;
    repeat (4) @(negedge clk);
    req("R11", 150, 80, 40, 33);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule